// File: doc/BRIEF.md
# Single-Cycle Load/Store/Branch Core

This block is a small 32-bit processor core that completes every instruction in one clock period. It supports register-to-register arithmetic and logic, word load, word store and branch-if-equal. In the same cycle, the program counter selects a word from a private instruction array, and a main decoder drives a register file, an ALU with a zero flag, a sign extender and two shared multiplexers. At the rising edge that ends the cycle, the PC, the register file and a private data array are updated together.

Instruction and data storage are separate arrays. This lets fetch and a data access happen in the same cycle. A loader port fills either array word by word, normally while the core is held in reset.

Every register write-back and every store is also driven onto trace outputs in the cycle it happens. The trace outputs give visibility into the core's commits.

Top module: `ss_core`

## Requirements
- R1: While `rst_ni` is low, the PC is 0. No register write or store is reported, and none takes effect.
- R2: The word at PC is executed, where the word index is PC bits [IA_W+1:2]. When no branch is taken, the next PC is PC + 4.
- R3: Instruction fields are opcode [31:26], rs [25:21], rt [20:16], rd [15:11] and funct [5:0]. Opcode 0 is R-type. It writes rd with rs op rt for funct 0x20 add, 0x22 sub, 0x24 and, 0x25 or, and 0x2A signed set-less-than (result 1 or 0).
- R4: Opcode 0x23 loads a word. It reads the data word at rs + sign-extended imm[15:0] and writes it to rt.
- R5: Opcode 0x2B stores rt at byte address rs + sign-extended imm[15:0], and writes no register. A later load from that address returns the stored value.
- R6: Opcode 0x04 branches when rs equals rt. The next PC is then PC + 4 + (sign-extended imm << 2); otherwise it is PC + 4. A branch writes no register.
- R7: Register 0 always reads as zero, and a write aimed at it has no effect.
- R8: An R-type funct outside the five listed codes, or any other opcode, writes no register and no memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ld_we_i | input | 1 | Loader write strobe |
| ld_dmem_i | input | 1 | Loader target: 1 = data array, 0 = instruction array |
| ld_addr_i | input | LD_AW | Loader word address |
| ld_data_i | input | 32 | Loader write word |
| pc_o | output | 32 | Current program counter |
| wb_en_o | output | 1 | A register is written at the end of this cycle |
| wb_reg_o | output | 5 | Register being written |
| wb_data_o | output | 32 | Value being written |
| st_en_o | output | 1 | A store happens at the end of this cycle |
| st_addr_o | output | 32 | Store byte address |
| st_data_o | output | 32 | Store data |

## Verification
On every cycle, assertions check the PC step: PC + 4 when no branch is taken, and the branch target when one is. They also check that register 0 keeps holding zero, that the decoder never asks for more than one kind of side effect, and that the zero flag matches operand equality on subtracts. Computed values need a running program, so only the bench scenarios can show them: arithmetic results including the signed compare, sign-extended load and store addresses, a store followed by a load of the same word, skipped instructions behind a taken branch, ignored unsupported codes, and a reset in the middle of a run.

// File: rtl/ss_core_pkg.sv
`timescale 1ns/1ps
package ss_core_pkg;
  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } alu_op_e;

  typedef struct packed {
    logic    reg_write;
    logic    dst_rd;
    logic    src_imm;
    logic    wb_mem;
    logic    mem_write;
    logic    branch;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/ss_decoder.sv
`timescale 1ns/1ps
module ss_decoder
  import ss_core_pkg::*;
(
  input  logic [5:0] opcode_i,
  input  logic [5:0] funct_i,
  output ctrl_t      ctrl_o
);
  always_comb begin
    ctrl_o = '0;
    ctrl_o.alu_op = ALU_ADD;
    unique case (opcode_i)
      OP_RTYPE: begin
        ctrl_o.reg_write = 1'b1;
        ctrl_o.dst_rd    = 1'b1;
        unique case (funct_i)
          FN_ADD:  ctrl_o.alu_op = ALU_ADD;
          FN_SUB:  ctrl_o.alu_op = ALU_SUB;
          FN_AND:  ctrl_o.alu_op = ALU_AND;
          FN_OR:   ctrl_o.alu_op = ALU_OR;
          FN_SLT:  ctrl_o.alu_op = ALU_SLT;
          default: ctrl_o.reg_write = 1'b0; // R8: unknown funct is a no-op
        endcase
      end
      OP_LW: begin
        ctrl_o.reg_write = 1'b1;
        ctrl_o.src_imm   = 1'b1;
        ctrl_o.wb_mem    = 1'b1;
      end
      OP_SW: begin
        ctrl_o.mem_write = 1'b1;
        ctrl_o.src_imm   = 1'b1;
      end
      OP_BEQ: begin
        ctrl_o.branch = 1'b1;
        ctrl_o.alu_op = ALU_SUB;
      end
      default: ;
    endcase
  end

  // R5/R6/R8: at most one kind of side effect per instruction
  always_comb begin
    a_r5_one_effect: assert ($onehot0({ctrl_o.reg_write, ctrl_o.mem_write, ctrl_o.branch}));
  end
endmodule

// File: rtl/ss_alu.sv
`timescale 1ns/1ps
module ss_alu
  import ss_core_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] res_o,
  output logic         zero_o
);
  always_comb begin
    unique case (op_i)
      ALU_SUB: res_o = a_i - b_i;
      ALU_AND: res_o = a_i & b_i;
      ALU_OR:  res_o = a_i | b_i;
      ALU_SLT: res_o = {{(W-1){1'b0}}, $signed(a_i) < $signed(b_i)};
      default: res_o = a_i + b_i;
    endcase
  end
  assign zero_o = (res_o == '0);

  always_comb begin
    if (op_i == ALU_SUB) a_r6_zero_means_equal: assert (zero_o == (a_i == b_i));
  end
endmodule

// File: rtl/ss_regfile.sv
`timescale 1ns/1ps
module ss_regfile #(
  parameter int unsigned NREG = 32,
  parameter int unsigned W    = 32,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra_i,
  input  logic [AW-1:0] rb_i,
  output logic [W-1:0]  rda_o,
  output logic [W-1:0]  rdb_o,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [W-1:0]  wd_i
);
  logic [W-1:0] regs_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (we_i && wa_i != '0) begin
      regs_q[wa_i] <= wd_i;
    end
  end

  assign rda_o = (ra_i == '0) ? '0 : regs_q[ra_i];
  assign rdb_o = (rb_i == '0) ? '0 : regs_q[rb_i];

  a_r7_zero_reg_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wa_i == '0) |=> (regs_q[0] == '0));
endmodule

// File: rtl/ss_core.sv
`timescale 1ns/1ps
module ss_core
  import ss_core_pkg::*;
#(
  parameter int unsigned IMEM_WORDS = 64,
  parameter int unsigned DMEM_WORDS = 64,
  localparam int unsigned IA_W  = $clog2(IMEM_WORDS),
  localparam int unsigned DA_W  = $clog2(DMEM_WORDS),
  localparam int unsigned LD_AW = (IA_W > DA_W) ? IA_W : DA_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_we_i,
  input  logic             ld_dmem_i,
  input  logic [LD_AW-1:0] ld_addr_i,
  input  logic [31:0]      ld_data_i,
  output logic [31:0]      pc_o,
  output logic             wb_en_o,
  output logic [4:0]       wb_reg_o,
  output logic [31:0]      wb_data_o,
  output logic             st_en_o,
  output logic [31:0]      st_addr_o,
  output logic [31:0]      st_data_o
);
  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] dmem [DMEM_WORDS];

  logic [31:0] pc_q, pc_plus4, br_target, instr, imm_ext;
  logic [31:0] rs_val, rt_val, alu_b, alu_res, wb_data, mem_rdata;
  logic [4:0]  wa;
  logic        zero, take_br;
  ctrl_t       ctrl;
  logic        unused_bits;

  // fetch
  assign instr = imem[pc_q[IA_W+1:2]];
  assign unused_bits = ^instr[10:6];

  ss_decoder u_dec (
    .opcode_i (instr[31:26]),
    .funct_i  (instr[5:0]),
    .ctrl_o   (ctrl)
  );

  assign imm_ext = {{16{instr[15]}}, instr[15:0]};
  assign wa      = ctrl.dst_rd ? instr[15:11] : instr[20:16];

  ss_regfile #(.NREG(32), .W(32)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ra_i   (instr[25:21]),
    .rb_i   (instr[20:16]),
    .rda_o  (rs_val),
    .rdb_o  (rt_val),
    .we_i   (ctrl.reg_write),
    .wa_i   (wa),
    .wd_i   (wb_data)
  );

  assign alu_b = ctrl.src_imm ? imm_ext : rt_val;

  ss_alu #(.W(32)) u_alu (
    .a_i    (rs_val),
    .b_i    (alu_b),
    .op_i   (ctrl.alu_op),
    .res_o  (alu_res),
    .zero_o (zero)
  );

  assign mem_rdata = dmem[alu_res[DA_W+1:2]];
  assign wb_data   = ctrl.wb_mem ? mem_rdata : alu_res;

  // next PC
  assign pc_plus4  = pc_q + 32'd4;
  assign br_target = pc_plus4 + {imm_ext[29:0], 2'b00};
  assign take_br   = ctrl.branch & zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= take_br ? br_target : pc_plus4;
  end

  // storage arrays; loader wins over a store in the same cycle
  always_ff @(posedge clk_i) begin
    if (ld_we_i && !ld_dmem_i) imem[ld_addr_i[IA_W-1:0]] <= ld_data_i;
  end

  always_ff @(posedge clk_i) begin
    if (ld_we_i && ld_dmem_i)           dmem[ld_addr_i[DA_W-1:0]] <= ld_data_i;
    else if (rst_ni && ctrl.mem_write)  dmem[alu_res[DA_W+1:2]]   <= rt_val;
  end

  assign pc_o      = pc_q;
  assign wb_en_o   = rst_ni & ctrl.reg_write & (wa != 5'd0);
  assign wb_reg_o  = wa;
  assign wb_data_o = wb_data;
  assign st_en_o   = rst_ni & ctrl.mem_write;
  assign st_addr_o = alu_res;
  assign st_data_o = rt_val;

  a_r2_seq_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_br |=> (pc_q == $past(pc_q) + 32'd4));

  a_r6_branch_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_br |=> (pc_q == $past(pc_q) + 32'd4 + {$past(imm_ext[29:0]), 2'b00}));

  a_r1_pc_word_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_q[1:0] == 2'b00);
endmodule

// File: tb/sim_ss_core.sv
`timescale 1ns/1ps
module sim_ss_core;
  localparam int unsigned LD_AW = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ld_we = 1'b0, ld_dmem = 1'b0;
  logic [LD_AW-1:0] ld_addr = '0;
  logic [31:0]      ld_data = '0;
  logic [31:0]      pc, wb_data, st_addr, st_data;
  logic             wb_en, st_en;
  logic [4:0]       wb_reg;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ss_core u0 (
    .clk_i(clk), .rst_ni(rst_n), .ld_we_i(ld_we), .ld_dmem_i(ld_dmem),
    .ld_addr_i(ld_addr), .ld_data_i(ld_data), .pc_o(pc), .wb_en_o(wb_en),
    .wb_reg_o(wb_reg), .wb_data_o(wb_data), .st_en_o(st_en),
    .st_addr_o(st_addr), .st_data_o(st_data)
  );

  typedef struct packed {
    logic [31:0] pc;
    logic        wb;
    logic [4:0]  rd;
    logic [31:0] wd;
    logic        st;
    logic [31:0] sa;
    logic [31:0] sd;
  } vec_t;

  localparam int NV = 19;
  // expected commit trace, one entry per cycle after reset release
  localparam vec_t VEC [NV] = '{
    '{32'd0,  1, 5'd1,  32'd5,        0, 32'd0,  32'd0}, // R4 lw r1
    '{32'd4,  1, 5'd2,  32'd3,        0, 32'd0,  32'd0}, // R4 lw r2
    '{32'd8,  1, 5'd3,  32'hFFFFFFFE, 0, 32'd0,  32'd0}, // R4 lw r3
    '{32'd12, 1, 5'd4,  32'd8,        0, 32'd0,  32'd0}, // R3 add
    '{32'd16, 1, 5'd5,  32'hFFFFFFFE, 0, 32'd0,  32'd0}, // R3 sub
    '{32'd20, 1, 5'd6,  32'd1,        0, 32'd0,  32'd0}, // R3 and
    '{32'd24, 1, 5'd7,  32'd7,        0, 32'd0,  32'd0}, // R3 or
    '{32'd28, 1, 5'd8,  32'd1,        0, 32'd0,  32'd0}, // R3 slt -2<5
    '{32'd32, 1, 5'd9,  32'd0,        0, 32'd0,  32'd0}, // R3 slt 5<-2
    '{32'd36, 0, 5'd0,  32'd0,        0, 32'd0,  32'd0}, // R7 add to r0
    '{32'd40, 0, 5'd0,  32'd0,        0, 32'd0,  32'd0}, // R8 funct 0x27
    '{32'd44, 0, 5'd0,  32'd0,        1, 32'd12, 32'd8}, // R5 sw r4
    '{32'd48, 0, 5'd0,  32'd0,        1, 32'd20, 32'd0}, // R7 sw r0
    '{32'd52, 1, 5'd10, 32'd8,        0, 32'd0,  32'd0}, // R5 load back
    '{32'd56, 1, 5'd11, 32'd3,        0, 32'd0,  32'd0}, // R4 negative imm
    '{32'd60, 0, 5'd0,  32'd0,        0, 32'd0,  32'd0}, // R6 not taken
    '{32'd64, 0, 5'd0,  32'd0,        0, 32'd0,  32'd0}, // R6 taken
    '{32'd76, 0, 5'd0,  32'd0,        0, 32'd0,  32'd0}, // R6 target, R2
    '{32'd76, 0, 5'd0,  32'd0,        0, 32'd0,  32'd0}  // R6 backward
  };

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input int imm);
    return {op, rs[4:0], rt[4:0], imm[15:0]};
  endfunction

  task automatic load_word(input logic to_dmem, input int addr, input logic [31:0] w);
    ld_we = 1'b1; ld_dmem = to_dmem; ld_addr = addr[LD_AW-1:0]; ld_data = w;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  function automatic vec_t observed();
    vec_t v;
    v.pc = pc;
    v.wb = wb_en;  v.rd = wb_en ? wb_reg : '0;   v.wd = wb_en ? wb_data : '0;
    v.st = st_en;  v.sa = st_en ? st_addr : '0;  v.sd = st_en ? st_data : '0;
    return v;
  endfunction

  task automatic check(input string req, input logic [134:0] act, input logic [134:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // data preload
    load_word(1'b1, 0, 32'd5);
    load_word(1'b1, 1, 32'd3);
    load_word(1'b1, 2, 32'hFFFFFFFE);
    load_word(1'b1, 3, 32'd7);
    // program
    load_word(1'b0, 0,  enc_i(6'h23, 0, 1, 0));
    load_word(1'b0, 1,  enc_i(6'h23, 0, 2, 4));
    load_word(1'b0, 2,  enc_i(6'h23, 0, 3, 8));
    load_word(1'b0, 3,  enc_r(1, 2, 4, 6'h20));
    load_word(1'b0, 4,  enc_r(2, 1, 5, 6'h22));
    load_word(1'b0, 5,  enc_r(1, 2, 6, 6'h24));
    load_word(1'b0, 6,  enc_r(1, 2, 7, 6'h25));
    load_word(1'b0, 7,  enc_r(3, 1, 8, 6'h2A));
    load_word(1'b0, 8,  enc_r(1, 3, 9, 6'h2A));
    load_word(1'b0, 9,  enc_r(1, 2, 0, 6'h20));
    load_word(1'b0, 10, enc_r(1, 2, 14, 6'h27));
    load_word(1'b0, 11, enc_i(6'h2B, 0, 4, 12));
    load_word(1'b0, 12, enc_i(6'h2B, 0, 0, 20));
    load_word(1'b0, 13, enc_i(6'h23, 0, 10, 12));
    load_word(1'b0, 14, enc_i(6'h23, 4, 11, -4));
    load_word(1'b0, 15, enc_i(6'h04, 1, 2, 5));
    load_word(1'b0, 16, enc_i(6'h04, 4, 10, 2));
    load_word(1'b0, 17, enc_r(1, 1, 12, 6'h20));
    load_word(1'b0, 18, enc_r(1, 1, 13, 6'h20));
    load_word(1'b0, 19, enc_i(6'h04, 0, 0, -1));

    // R1: held in reset
    #1;
    check("R1 reset pc/no effects", {pc, wb_en, st_en, 101'd0}, 135'd0);

    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      #1;
      check($sformatf("R2 R3 R4 R5 R6 R7 R8 step %0d", i), observed(), VEC[i]);
      @(negedge clk);
    end

    // R1: reset mid-run, asynchronous
    rst_n = 1'b0;
    #1;
    check("R1 async reset mid-run", {pc, wb_en, st_en, 101'd0}, 135'd0);
    @(negedge clk);
    #1;
    check("R1 pc held in reset", {pc, wb_en, st_en, 101'd0}, 135'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 R4 restart from 0", observed(), VEC[0]);
    @(negedge clk);
    #1;
    check("R2 restart step", observed(), VEC[1]);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule